// File: doc/BRIEF.md
# Serial Character Transmitter with Line Break and IR Line Modes

This block serialises one byte at a time onto a line. A byte written to the holding register moves into a shift register at the next bit-cell boundary. It then goes out as a start bit, five to eight data bits (least significant first), an optional parity bit and one, one-and-a-half or two stop bits. Time is measured in a 16-tick phase cell, advanced by a one-cycle `bit_tick` strobe from an external rate generator. One full bit takes 16 ticks and a half stop bit takes 8. The framing comes from a 7-bit line control value written over a small write-only register bus. A byte written while a character is still being sent begins immediately after that character's last full stop bit.

A two-bit mode input picks how the serial bit stream reaches the pins: a wired UART output, a short-pulse infrared output, a Sharp-style infrared output with or without internal modulation, or a consumer-infrared output. A break control overrides only this output stage. The shifter, the holding register and the empty flag carry on as normal, so sending characters during a break measures out its length.

The controller has six states. IDLE waits for a full holding register. START sends the start bit. DATA sends the data bits. PARITY sends the parity bit. STOP sends the first stop bit. STOP_EXT sends the extra stop time. The transitions are:
- IDLE→START: at a cell end with the holding register full (this loads the byte).
- START→DATA: at a cell end.
- DATA→PARITY, or DATA→STOP when parity is off: at the cell end of the last data bit.
- PARITY→STOP: at a cell end.
- STOP→STOP_EXT: when the two-stop setting is on.
- STOP→START: when another byte waits.
- STOP→IDLE: otherwise.
- STOP_EXT→IDLE or STOP_EXT→START: after 8 ticks for 5-bit characters (always to IDLE), after 16 ticks otherwise.

Top module: `sertx_framer`

## Requirements
- R1: After reset, the line control value is all zero (5 data bits, one stop bit, no parity, no break), `uart_txd` is 1, `ir_txd` is 0 and `tx_empty` is 1.
- R2: A character begins at a phase-cell boundary (phase 15 to 0) and has this frame: a 0 start bit, then data bits least significant first, each lasting 16 ticks. Control bits [1:0] set the data length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits. The idle line is 1.
- R3: Control bit 2 = 0 gives one stop bit. Control bit 2 = 1 gives two stop bits for 6, 7 or 8 data bits, and one and a half stop bits (16 + 8 ticks) for 5 data bits.
- R4: Control bit 3 enables a parity bit after the data. With parity enabled, bit 5 (stick) and bit 4 (even) set its value: 00 gives odd parity, 01 gives even parity, 10 gives a constant 1, 11 gives a constant 0.
- R5: A byte written while a character is being sent starts directly after that character's last full stop bit, with no idle cell in between. After a half stop bit, the next start waits for the next cell boundary.
- R6: `tx_empty` is 1 exactly when the holding register is empty and the shifter has finished its last stop time, including a half stop bit.
- R7: The framing in force when a byte is loaded is kept for that whole character. Later control writes take effect from the next character.
- R8: Control bit 6 (break) in UART mode holds `uart_txd` at 0. Character timing and `tx_empty` carry on unchanged.
- R9: Mode encoding is 00 UART, 01 short-pulse IR, 10 Sharp IR, 11 consumer IR. Outside UART mode `uart_txd` is 1, and in UART mode `ir_txd` is 0. In short-pulse IR, and in Sharp IR with `ir_mod_en` = 1, a 0 bit drives `ir_txd` high for phase ticks 0 to 2 of each cell. In Sharp IR with `ir_mod_en` = 0, `ir_txd` is the inverse of the line bit.
- R10: During a break, short-pulse IR mode and modulated Sharp IR mode send the pulse continuously in every cell. Unmodulated Sharp IR mode holds `ir_txd` at 1.
- R11: In consumer-IR mode, control bits 6 to 0 are ignored. Characters use 8 data bits, no parity and one stop bit, with no break, and `ir_txd` is the inverse of the line bit.
- R12: A write to the control address with bit 7 set is a bank-select write and leaves the framing and break bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe advancing the 16-tick phase |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = holding register, 1 = line control |
| wr_data | input | 8 | Write data |
| mode | input | 2 | Line mode (see R9) |
| ir_mod_en | input | 1 | Internal modulation enable for Sharp IR mode |
| uart_txd | output | 1 | Wired serial output |
| ir_txd | output | 1 | Infrared output |
| tx_empty | output | 1 | Holding register and shifter both idle |

## Verification
The bench targets the half stop bit of 5-bit characters. A design that rounds it up to a full bit would hold `tx_empty` low 8 ticks too long, and one that skips it would show a single stop. It drives all four stick/even parity settings on data with odd and even numbers of ones, where a swapped parity table shows up as an inverted parity cell. It sends back-to-back bytes and rewrites the control value mid-character, catching both an idle gap between characters and framing that changes inside a character. It raises break in every mode and writes bank-select and consumer-IR control values, which catches a break that stalls the shifter, pulses in the wrong phase, or control bits that leak through.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [1:0] {
        MODE_UART  = 2'd0,
        MODE_SIR   = 2'd1,
        MODE_SHARP = 2'd2,
        MODE_CIR   = 2'd3
    } line_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_STOP_EXT
    } tx_state_e;

    typedef struct packed {
        logic       stick;
        logic       even;
        logic       par_en;
        logic       two_stop;
        logic [1:0] len;
    } frame_cfg_t;

endpackage

// File: rtl/sertx_phase.sv
module sertx_phase #(
    parameter int OVS  = 16,
    localparam int PH_W = $clog2(OVS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_tick,
    output logic [PH_W-1:0] ph,
    output logic            cell_end,
    output logic            half_end
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph <= '0;
        else if (bit_tick)
            ph <= (ph == PH_W'(OVS - 1)) ? '0 : ph + 1'b1;
    end

    assign cell_end = bit_tick && (ph == PH_W'(OVS - 1));
    assign half_end = bit_tick && (ph == PH_W'(OVS / 2 - 1));
endmodule

// File: rtl/sertx_regs.sv
module sertx_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              load,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full,
    output logic [6:0]        lcr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcr <= '0;
        end else if (wr_en && wr_addr && !wr_data[7]) begin
            lcr <= wr_data[6:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_full <= 1'b0;
        end else if (wr_en && !wr_addr) begin
            hold_data <= wr_data[DATA_W-1:0];
            hold_full <= 1'b1;
        end else if (load) begin
            hold_full <= 1'b0;
        end
    end
endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cell_end,
    input  logic              half_end,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  frame_cfg_t        cfg,
    output logic              load,
    output logic              line_bit,
    output logic              busy
);
    tx_state_e         state, nxt;
    frame_cfg_t        f;
    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  last_idx;
    logic              pbit;
    logic              pcalc;
    logic              ext_done;

    assign last_idx = IDX_W'(4) + IDX_W'(f.len);
    assign ext_done = (f.len == 2'd0) ? half_end : cell_end;

    // parity over the data bits that will be sent
    always_comb begin
        logic [3:0]        nbits;
        logic [DATA_W-1:0] masked;
        nbits = 4'd5 + {2'b00, cfg.len};
        for (int i = 0; i < DATA_W; i++)
            masked[i] = hold_data[i] && (i < int'(nbits));
        if (cfg.stick)
            pcalc = ~cfg.even;
        else
            pcalc = cfg.even ? ^masked : ~^masked;
    end

    always_comb begin
        nxt  = state;
        load = 1'b0;
        unique case (state)
            ST_IDLE: if (cell_end && hold_full) begin
                nxt  = ST_START;
                load = 1'b1;
            end
            ST_START: if (cell_end) nxt = ST_DATA;
            ST_DATA: if (cell_end && idx == last_idx)
                nxt = f.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (cell_end) nxt = ST_STOP;
            ST_STOP: if (cell_end) begin
                if (f.two_stop) begin
                    nxt = ST_STOP_EXT;
                end else if (hold_full) begin
                    nxt  = ST_START;
                    load = 1'b1;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            ST_STOP_EXT: if (ext_done) begin
                if (f.len != 2'd0 && hold_full) begin
                    nxt  = ST_START;
                    load = 1'b1;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            idx   <= '0;
            f     <= '0;
            pbit  <= 1'b0;
        end else if (load) begin
            shreg <= hold_data;
            idx   <= '0;
            f     <= cfg;
            pbit  <= pcalc;
        end else if (state == ST_DATA && cell_end) begin
            shreg <= shreg >> 1;
            idx   <= idx + 1'b1;
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE:     line_bit = 1'b1;
            ST_START:    line_bit = 1'b0;
            ST_DATA:     line_bit = shreg[0];
            ST_PARITY:   line_bit = pbit;
            ST_STOP:     line_bit = 1'b1;
            ST_STOP_EXT: line_bit = 1'b1;
            default:     line_bit = 1'b1;
        endcase
        busy = (state != ST_IDLE);
    end
endmodule

// File: rtl/sertx_front.sv
module sertx_front
    import sertx_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int PULSE_LEN = 3,
    localparam int PH_W     = $clog2(OVS)
) (
    input  line_mode_e      mode,
    input  logic            brk,
    input  logic            ir_mod_en,
    input  logic [PH_W-1:0] ph,
    input  logic            line_bit,
    output logic            uart_txd,
    output logic            ir_txd
);
    logic pulse;
    logic mark;

    assign pulse = (ph < PH_W'(PULSE_LEN));
    assign mark  = brk || !line_bit;

    always_comb begin
        uart_txd = 1'b1;
        ir_txd   = 1'b0;
        unique case (mode)
            MODE_UART:  uart_txd = brk ? 1'b0 : line_bit;
            MODE_SIR:   ir_txd = mark && pulse;
            MODE_SHARP: ir_txd = ir_mod_en ? (mark && pulse) : (brk || !line_bit);
            MODE_CIR:   ir_txd = !line_bit;
            default:    ir_txd = 1'b0;
        endcase
    end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int OVS       = 16,
    parameter int PULSE_LEN = 3,
    localparam int PH_W     = $clog2(OVS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] mode,
    input  logic       ir_mod_en,
    output logic       uart_txd,
    output logic       ir_txd,
    output logic       tx_empty
);
    line_mode_e        lmode;
    logic [PH_W-1:0]   ph;
    logic              cell_end, half_end;
    logic              load, line_bit, busy, brk;
    logic [DATA_W-1:0] hold_data;
    logic              hold_full;
    logic [6:0]        lcr;
    frame_cfg_t        cfg_eff;

    assign lmode = line_mode_e'(mode);
    assign brk   = lcr[6] && (lmode != MODE_CIR);

    always_comb begin
        if (lmode == MODE_CIR)
            cfg_eff = '{stick: 1'b0, even: 1'b0, par_en: 1'b0, two_stop: 1'b0, len: 2'b11};
        else
            cfg_eff = '{stick: lcr[5], even: lcr[4], par_en: lcr[3], two_stop: lcr[2], len: lcr[1:0]};
    end

    sertx_phase #(.OVS(OVS)) u_phase (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .ph(ph), .cell_end(cell_end), .half_end(half_end)
    );

    sertx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .load(load), .hold_data(hold_data),
        .hold_full(hold_full), .lcr(lcr)
    );

    sertx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cell_end(cell_end), .half_end(half_end),
        .hold_full(hold_full), .hold_data(hold_data), .cfg(cfg_eff),
        .load(load), .line_bit(line_bit), .busy(busy)
    );

    sertx_front #(.OVS(OVS), .PULSE_LEN(PULSE_LEN)) u_front (
        .mode(lmode), .brk(brk), .ir_mod_en(ir_mod_en), .ph(ph),
        .line_bit(line_bit), .uart_txd(uart_txd), .ir_txd(ir_txd)
    );

    assign tx_empty = !busy && !hold_full;
endmodule

// File: rtl/sertx_framer_chk.sv
module sertx_framer_chk #(
    parameter int OVS       = 16,
    parameter int PULSE_LEN = 3,
    localparam int PH_W     = $clog2(OVS)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bit_tick,
    input logic [1:0]      mode,
    input logic            brk,
    input logic [PH_W-1:0] ph,
    input logic            uart_txd,
    input logic            ir_txd,
    input logic            tx_empty
);
    // R2: phase advances only on a tick
    a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(ph));

    // R6: the empty flag can only rise on a tick boundary
    a_r6_empty_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> $past(bit_tick));

    // R8: break in UART mode keeps the wired line low
    a_r8_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && brk) |-> !uart_txd);

    // R9: wired output stays high outside UART mode
    a_r9_uart_idle_ir: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0) |-> uart_txd);

    // R9: IR output quiet in UART mode
    a_r9_ir_quiet_uart: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> !ir_txd);

    // R10: short-pulse IR is silent outside the pulse window
    a_r10_pulse_window: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && ph >= PH_W'(PULSE_LEN)) |-> !ir_txd);
endmodule

bind sertx_framer sertx_framer_chk #(.OVS(OVS), .PULSE_LEN(PULSE_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .mode(mode), .brk(brk),
    .ph(ph), .uart_txd(uart_txd), .ir_txd(ir_txd), .tx_empty(tx_empty)
);

// File: tb/sertx_framer_tb.sv
module sertx_framer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] mode = 2'd0;
    logic       ir_mod_en = 1'b0;
    logic       uart_txd, ir_txd, tx_empty;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    sertx_framer u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .mode(mode),
        .ir_mod_en(ir_mod_en), .uart_txd(uart_txd), .ir_txd(ir_txd),
        .tx_empty(tx_empty)
    );

    // tick every fourth clock
    int tcnt = 0;
    always @(negedge clk) begin
        tcnt     = (tcnt + 1) % 4;
        bit_tick = (tcnt == 3);
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int   m_ph = 0;
    bit   m_q[$];
    bit   m_full = 0;
    int   m_hold = 0;
    int   m_lcr = 0;

    function automatic void push_cell(input bit b, input int n);
        for (int k = 0; k < n; k++) m_q.push_back(b);
    endfunction

    function automatic void build_frame(input int data, input int c);
        int nb, ones;
        bit p;
        nb = 5 + (c & 3);
        ones = 0;
        push_cell(1'b0, 16);
        for (int b = 0; b < nb; b++) begin
            push_cell(((data >> b) & 1) != 0, 16);
            ones += (data >> b) & 1;
        end
        if ((c & 8) != 0) begin
            if ((c & 32) != 0)      p = ((c & 16) == 0);
            else if ((c & 16) != 0) p = (ones % 2) == 1;
            else                    p = (ones % 2) == 0;
            push_cell(p, 16);
        end
        push_cell(1'b1, 16);
        if ((c & 4) != 0) push_cell(1'b1, (nb == 5) ? 8 : 16);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_q.delete(); m_full = 0; m_hold = 0; m_lcr = 0;
        end else begin
            if (bit_tick) begin
                if (m_q.size() > 0) void'(m_q.pop_front());
                if (m_ph == 15 && m_q.size() == 0 && m_full) begin
                    build_frame(m_hold, (mode == 2'd3) ? 3 : m_lcr);
                    m_full = 0;
                end
                m_ph = (m_ph + 1) % 16;
            end
            if (wr_en && !wr_addr) begin m_hold = wr_data; m_full = 1; end
            if (wr_en && wr_addr && !wr_data[7]) m_lcr = wr_data & 8'h7f;
        end
    end

    // compare a quarter period after each rising edge
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            bit lb, brk, mk, eu, ei;
            lb  = (m_q.size() > 0) ? m_q[0] : 1'b1;
            brk = ((m_lcr & 64) != 0) && (mode != 2'd3);
            mk  = brk || !lb;
            eu = 1'b1; ei = 1'b0;
            case (mode)
                2'd0: eu = brk ? 1'b0 : lb;
                2'd1: ei = mk && (m_ph < 3);
                2'd2: ei = ir_mod_en ? (mk && (m_ph < 3)) : mk;
                default: ei = !lb;
            endcase
            chk({cur_req, " uart_txd"}, int'(uart_txd), int'(eu));
            chk({cur_req, " ir_txd"}, int'(ir_txd), int'(ei));
            chk("R6 tx_empty", int'(tx_empty), int'(m_q.size() == 0 && !m_full));
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input bit a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (!tx_empty) @(negedge clk);
        repeat (80) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] c, input logic [7:0] d);
        wr(1'b1, c);
        wr(1'b0, d);
        drain();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #5;
        chk("R1 uart_txd reset", int'(uart_txd), 1);
        chk("R1 ir_txd reset", int'(ir_txd), 0);
        chk("R1 tx_empty reset", int'(tx_empty), 1);

        cur_req = "R1 default 5N1";
        wr(1'b0, 8'h35); drain();
        cur_req = "R2 lengths";
        send(8'h03, 8'hA5);
        send(8'h01, 8'h2E);
        send(8'h02, 8'h4B);
        cur_req = "R3 stop bits";
        send(8'h07, 8'hC3);
        send(8'h04, 8'h16);
        send(8'h05, 8'h3A);
        cur_req = "R4 parity";
        send(8'h0B, 8'h07);
        send(8'h1B, 8'h07);
        send(8'h0B, 8'h03);
        send(8'h1B, 8'h03);
        send(8'h2B, 8'h00);
        send(8'h3B, 8'hFF);

        cur_req = "R5 back to back";
        wr(1'b1, 8'h03);
        wr(1'b0, 8'h5A);
        repeat (200) @(negedge clk);
        wr(1'b0, 8'hC6);
        drain();
        wr(1'b1, 8'h04);
        wr(1'b0, 8'h11);
        repeat (200) @(negedge clk);
        wr(1'b0, 8'h0E);
        drain();

        cur_req = "R7 latch at load";
        wr(1'b1, 8'h0B);
        wr(1'b0, 8'h96);
        repeat (300) @(negedge clk);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h1D);
        drain();

        cur_req = "R8 uart break";
        wr(1'b1, 8'h43);
        wr(1'b0, 8'h55);
        drain();
        wr(1'b1, 8'h03);
        repeat (40) @(negedge clk);

        cur_req = "R9 sir data";
        mode = 2'd1; send(8'h03, 8'h6C);
        cur_req = "R9 sharp mod data";
        mode = 2'd2; ir_mod_en = 1'b1; send(8'h03, 8'h93);
        cur_req = "R9 sharp plain data";
        ir_mod_en = 1'b0; send(8'h0B, 8'h2D);

        cur_req = "R10 ir break";
        mode = 2'd1; wr(1'b1, 8'h43); repeat (150) @(negedge clk);
        mode = 2'd2; ir_mod_en = 1'b1; repeat (150) @(negedge clk);
        ir_mod_en = 1'b0; wr(1'b0, 8'hA1); drain();
        wr(1'b1, 8'h03);

        cur_req = "R11 consumer ir";
        mode = 2'd3;
        send(8'h7C, 8'hB4);
        mode = 2'd0;
        cur_req = "R11 back to uart";
        wr(1'b1, 8'h03); drain();

        cur_req = "R12 bank write";
        wr(1'b1, 8'hC4);
        wr(1'b0, 8'h9E);
        drain();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule